// File: doc/BRIEF.md
# Tick Counter With Compare Interrupt

This block keeps a 63-bit tick count that advances by one on every cycle in which the tick enable input is high. It also holds a compare register. When the count reaches the programmed compare value, the block raises a level interrupt request. That request stays up until software acknowledges it or reprograms the compare register.

Software reaches both registers through a single-cycle register-access port that carries a privilege indication. Read data and a fault code are returned combinationally in the same cycle as the request. A write takes effect at the next clock edge, and only if it raised no fault.

The count is not held as a loadable register. It is the difference between a free-running time base and a stored offset, so a counter write simply relocates the offset. Bit 63 of the counter carries a flag that forbids non-privileged reads. Bit 63 of the compare register is a disable flag.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, `irqReq` is 0. A privileged counter read returns all zeros, which means bit 63 (the read-protect flag) is 0. A privileged compare read returns bit 63 = 1 (disabled) with value 0 in bits 62..0.
- R2: The count read in bits 62..0 grows by exactly one after each clock edge at which `tickEn` is 1. It is unchanged after edges at which `tickEn` is 0.
- R3: A privileged counter write (`accSel`=0) loads bits 62..0 of the write data as the new count. If `tickEn` is high in the write cycle, the loaded count is that value plus one. Bit 63 of the write data becomes the read-protect flag. A counter read returns the read-protect flag in bit 63 and the count in bits 62..0.
- R4: A non-privileged counter read while the read-protect flag is 1 returns fault code 2 with read data 0. While the flag is 0, the same read succeeds with fault code 0.
- R5: A non-privileged counter write returns fault code 1 and leaves the count and the read-protect flag unchanged.
- R6: Any non-privileged compare access (`accSel`=1) returns fault code 1 with read data 0. A non-privileged compare write leaves the compare register unchanged.
- R7: A privileged compare write with bit 63 = 0 arms the match when its bits 62..0 are strictly greater than the count at the time of the write. `irqReq` then rises at the clock edge that closes the cycle in which the count equals the compare value.
- R8: A compare write whose value is at or below the current count never raises `irqReq`. This holds even if the count is later moved below the value and passes it again, until the compare register is rewritten.
- R9: A compare write with bit 63 = 1 cancels any pending match, so no interrupt is raised.
- R10: `irqReq` stays high until a cycle with `irqAck`=1, and it is low after that edge. A match in the same cycle as `irqAck` wins, and `irqReq` is high afterwards.
- R11: An accepted compare write clears `irqReq` at the next edge. It takes priority over a match that falls in the same cycle.
- R12: An accepted access returns fault code 0. A privileged compare read returns the stored disable flag in bit 63 and the value in bits 62..0. Idle cycles and writes return read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advance the count by one at this edge |
| accEn | input | 1 | Register access valid this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accSel | input | 1 | 0 = counter register, 1 = compare register |
| accPriv | input | 1 | Accessor is privileged |
| accWdata | input | 64 | Write data |
| irqAck | input | 1 | Clear the interrupt request |
| accRdata | output | 64 | Read data (0 on fault, write or idle) |
| accFault | output | 2 | 0 none, 1 privileged opcode, 2 privileged action |
| irqReq | output | 1 | Sticky compare-match interrupt request |

## Verification
A match can fall in the same cycle as an acknowledge. It can also fall in the same cycle as a fresh compare write. The bench provokes the first by holding `irqAck` high through the whole approach to an armed value. It provokes the second by issuing a compare write in exactly the cycle where the count has just stepped onto the armed value. A behavioural reference model checks, on every clock, that the match wins over the acknowledge and that the write wins over the match.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_PRIV_OPCODE = 2'd1,
    FLT_PRIV_ACTION = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CNT  = 2'd1,
    RD_CMP  = 2'd2
  } rd_sel_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic cntWr;
    logic cmpWr;
  } strobe_t;

endpackage

// File: rtl/tick_cmp_ctrl.sv
module tick_cmp_ctrl
  import tick_cmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    accEn,
  input  logic    accWr,
  input  logic    accSel,
  input  logic    accPriv,
  input  logic    wdataDis,
  input  logic    irqAck,
  input  logic    nptFlag,
  input  logic    cmpDis,
  input  logic    countEqCmp,
  input  logic    newCmpAbove,
  output strobe_t strobe,
  output fault_e  fault,
  output rd_sel_e rdSel,
  output logic    irqReq
);

  logic    isCnt;
  logic    isCmp;
  logic    armed;
  logic    match;

  assign isCnt = accEn && !accSel;
  assign isCmp = accEn && accSel;

  // fault decode
  always_comb begin
    fault = FLT_NONE;
    if (isCmp && !accPriv) begin
      fault = FLT_PRIV_OPCODE;
    end else if (isCnt && accWr && !accPriv) begin
      fault = FLT_PRIV_OPCODE;
    end else if (isCnt && !accWr && !accPriv && nptFlag) begin
      fault = FLT_PRIV_ACTION;
    end
  end

  // strobes and read select, only for accepted accesses
  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    if (fault == FLT_NONE) begin
      if (accWr) begin
        strobe.cntWr = isCnt;
        strobe.cmpWr = isCmp;
      end else if (isCnt) begin
        rdSel = RD_CNT;
      end else if (isCmp) begin
        rdSel = RD_CMP;
      end
    end
  end

  assign match = armed && countEqCmp;

  // arm / interrupt state: compare write > match > acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      irqReq <= 1'b0;
    end else if (strobe.cmpWr) begin
      armed  <= !wdataDis && newCmpAbove;
      irqReq <= 1'b0;
    end else if (match) begin
      armed  <= 1'b0;
      irqReq <= 1'b1;
    end else if (irqAck) begin
      irqReq <= 1'b0;
    end
  end

  // R5 / R6: a faulted access never produces a strobe
  a_r5_fault_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (fault != FLT_NONE) |-> (strobe == '0));

  // R9: a disabled compare register is never armed
  a_r9_dis_not_armed: assert property (@(posedge clk) disable iff (!rstN)
    cmpDis |-> !armed);

  // R7: the request only rises after an armed equality
  a_r7_rise_on_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(armed && countEqCmp));

  // R11: an accepted compare write drops the request
  a_r11_cmpwr_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpWr |=> !irqReq);

  // R10: the request is sticky without acknowledge or compare write
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck && !strobe.cmpWr) |=> irqReq);

endmodule

// File: rtl/tick_cmp_dpath.sv
module tick_cmp_dpath
  import tick_cmp_pkg::*;
#(
  parameter int TW = 63
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  strobe_t       strobe,
  input  rd_sel_e       rdSel,
  input  logic [TW:0]   wdata,
  output logic [TW:0]   rdata,
  output logic          nptFlag,
  output logic          cmpDis,
  output logic          countEqCmp,
  output logic          newCmpAbove
);

  localparam int DW = TW + 1;

  logic [TW-1:0] timeBase;
  logic [TW-1:0] offset;
  logic [TW-1:0] count;
  logic [TW-1:0] cmpVal;
  logic [TW-1:0] wrVal;
  logic [TW-1:0] tickInc;

  assign wrVal   = wdata[TW-1:0];
  assign tickInc = {{(TW-1){1'b0}}, tickEn};
  assign count   = timeBase - offset;

  // free-running time base
  always_ff @(posedge clk) begin
    if (!rstN) timeBase <= '0;
    else       timeBase <= timeBase + tickInc;
  end

  // counter relocation through the offset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offset  <= '0;
      nptFlag <= 1'b0;
    end else if (strobe.cntWr) begin
      offset  <= timeBase - wrVal;
      nptFlag <= wdata[TW];
    end
  end

  // compare register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpDis <= 1'b1;
      cmpVal <= '0;
    end else if (strobe.cmpWr) begin
      cmpDis <= wdata[TW];
      cmpVal <= wrVal;
    end
  end

  assign countEqCmp  = (count == cmpVal);
  assign newCmpAbove = (wrVal > count);

  always_comb begin
    unique case (rdSel)
      RD_CNT:  rdata = {nptFlag, count};
      RD_CMP:  rdata = {cmpDis, cmpVal};
      default: rdata = {DW{1'b0}};
    endcase
  end

  // R3: a counter write loads the written value (plus a coincident tick)
  a_r3_count_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntWr |=> (count == $past(wrVal) + $past(tickInc)));

  // R2: otherwise the count moves by the tick only
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntWr |=> (count == $past(count) + $past(tickInc)));

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int TW = 63
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          accEn,
  input  logic          accWr,
  input  logic          accSel,
  input  logic          accPriv,
  input  logic [TW:0]   accWdata,
  input  logic          irqAck,
  output logic [TW:0]   accRdata,
  output logic [1:0]    accFault,
  output logic          irqReq
);

  strobe_t strobe;
  fault_e  fault;
  rd_sel_e rdSel;
  logic    nptFlag;
  logic    cmpDis;
  logic    countEqCmp;
  logic    newCmpAbove;

  tick_cmp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accEn       (accEn),
    .accWr       (accWr),
    .accSel      (accSel),
    .accPriv     (accPriv),
    .wdataDis    (accWdata[TW]),
    .irqAck      (irqAck),
    .nptFlag     (nptFlag),
    .cmpDis      (cmpDis),
    .countEqCmp  (countEqCmp),
    .newCmpAbove (newCmpAbove),
    .strobe      (strobe),
    .fault       (fault),
    .rdSel       (rdSel),
    .irqReq      (irqReq)
  );

  tick_cmp_dpath #(.TW(TW)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .wdata       (accWdata),
    .rdata       (accRdata),
    .nptFlag     (nptFlag),
    .cmpDis      (cmpDis),
    .countEqCmp  (countEqCmp),
    .newCmpAbove (newCmpAbove)
  );

  assign accFault = fault;

endmodule

// File: tb/tick_cmp_timer_tb.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        accEn = 1'b0;
  logic        accWr = 1'b0;
  logic        accSel = 1'b0;
  logic        accPriv = 1'b0;
  logic [63:0] accWdata = '0;
  logic        irqAck = 1'b0;
  logic [63:0] accRdata;
  logic [1:0]  accFault;
  logic        irqReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [62:0] mCount;
  logic        mNpt, mDis, mArmed, mIrq;
  logic [62:0] mCmp;

  always #2.5 clk = ~clk;

  tick_cmp_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .accEn(accEn), .accWr(accWr),
    .accSel(accSel), .accPriv(accPriv), .accWdata(accWdata), .irqAck(irqAck),
    .accRdata(accRdata), .accFault(accFault), .irqReq(irqReq)
  );

  task automatic model_reset();
    mCount = '0; mNpt = 0; mDis = 1; mCmp = '0; mArmed = 0; mIrq = 0;
  endtask

  task automatic step(input bit tk, input bit en, input bit wr, input bit sel,
                      input bit pv, input logic [63:0] wd, input bit ack,
                      input string tag);
    logic [1:0]  eFault;
    logic [63:0] eData;
    bit          ok, match;
    @(negedge clk);
    tickEn = tk; accEn = en; accWr = wr; accSel = sel; accPriv = pv;
    accWdata = wd; irqAck = ack;
    #1;
    eFault = 2'd0; eData = '0;
    if (en) begin
      if (sel && !pv) eFault = 2'd1;
      else if (!sel && wr && !pv) eFault = 2'd1;
      else if (!sel && !wr && !pv && mNpt) eFault = 2'd2;
      if (eFault == 2'd0 && !wr) eData = sel ? {mDis, mCmp} : {mNpt, mCount};
    end
    ok = (accFault == eFault) && (accRdata == eData) && (irqReq == mIrq);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: fault=%0d rdata=%h irq=%0b expected fault=%0d rdata=%h irq=%0b",
               tag, accFault, accRdata, irqReq, eFault, eData, mIrq);
    end
    @(posedge clk);
    match = mArmed && (mCount == mCmp);
    if (en && wr && eFault == 2'd0 && sel) begin
      mDis = wd[63]; mCmp = wd[62:0];
      mArmed = !wd[63] && (wd[62:0] > mCount);
      mIrq = 0;
    end else if (match) begin
      mArmed = 0; mIrq = 1;
    end else if (ack) begin
      mIrq = 0;
    end
    if (en && wr && eFault == 2'd0 && !sel) begin
      mCount = wd[62:0] + 63'(tk); mNpt = wd[63];
    end else begin
      mCount = mCount + 63'(tk);
    end
  endtask

  task automatic idle(input bit tk, input string tag);
    step(tk, 0, 0, 0, 1, '0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    idle(0, "R1");
    step(0, 1, 0, 0, 1, '0, 0, "R1");
    step(0, 1, 0, 1, 1, '0, 0, "R1");
    // R2 ticking and holding
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 1, '0, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, '0, 0, "R2");
    // R3 counter write with protect flag and coincident tick
    step(1, 1, 1, 0, 1, {1'b1, 63'h100}, 0, "R3");
    step(0, 1, 0, 0, 1, '0, 0, "R3");
    step(0, 1, 1, 0, 1, {1'b0, 63'h7FFF_FFFF_FFFF_FFFE}, 0, "R3");
    step(1, 1, 0, 0, 1, '0, 0, "R3");
    step(1, 1, 0, 0, 1, '0, 0, "R3");
    step(0, 1, 1, 0, 1, {1'b1, 63'h40}, 0, "R3");
    // R4 protected read from non-privileged mode
    step(0, 1, 0, 0, 0, '0, 0, "R4");
    step(1, 1, 1, 0, 1, {1'b0, 63'h200}, 0, "R4");
    step(0, 1, 0, 0, 0, '0, 0, "R4");
    // R5 non-privileged counter write ignored
    step(0, 1, 1, 0, 0, {1'b1, 63'h5555}, 0, "R5");
    step(0, 1, 0, 0, 0, '0, 0, "R5");
    // R6 non-privileged compare accesses
    step(0, 1, 1, 1, 0, {1'b0, 63'h300}, 0, "R6");
    step(0, 1, 0, 1, 0, '0, 0, "R6");
    step(0, 1, 0, 1, 1, '0, 0, "R6");
    for (int i = 0; i < 4; i++) idle(1, "R6");
    // R7 armed match raises the request; R12 compare read-back
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd4}, 0, "R7");
    step(0, 1, 0, 1, 1, '0, 0, "R12");
    for (int i = 0; i < 8; i++) idle(1, "R7");
    // R10 acknowledge clears
    step(0, 0, 0, 0, 1, '0, 1, "R10");
    idle(0, "R10");
    // R8 compare at current count never fires, even after relocation
    step(0, 1, 1, 1, 1, {1'b0, mCount}, 0, "R8");
    for (int i = 0; i < 5; i++) idle(1, "R8");
    step(0, 1, 1, 0, 1, {1'b0, mCmp - 63'd3}, 0, "R8");
    for (int i = 0; i < 6; i++) idle(1, "R8");
    // R9 disable cancels a pending match
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd3}, 0, "R9");
    step(0, 1, 1, 1, 1, {1'b1, mCmp}, 0, "R9");
    for (int i = 0; i < 6; i++) idle(1, "R9");
    // R10 match coincident with held acknowledge
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd2}, 0, "R10");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, '0, 1, "R10");
    step(0, 0, 0, 0, 1, '0, 0, "R10");
    // R11 compare write drops a sticky request
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd1}, 0, "R11");
    for (int i = 0; i < 3; i++) idle(1, "R11");
    step(0, 1, 1, 1, 1, {1'b1, 63'h0}, 0, "R11");
    idle(0, "R11");
    // R11 compare write in the very cycle of a match
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd1}, 0, "R11");
    idle(1, "R11");
    step(0, 1, 1, 1, 1, {1'b0, mCount + 63'd50}, 0, "R11");
    for (int i = 0; i < 3; i++) idle(1, "R11");
    // R12 write and idle return zero data
    step(0, 1, 1, 0, 1, {1'b0, 63'h9}, 0, "R12");
    step(0, 1, 0, 0, 1, '0, 0, "R12");
    // R1 reset again restores defaults
    @(negedge clk); rstN = 1'b0; accEn = 0; tickEn = 0; irqAck = 0;
    @(posedge clk); model_reset();
    @(negedge clk); rstN = 1'b1;
    step(0, 1, 0, 1, 1, '0, 0, "R1");
    step(0, 1, 0, 0, 1, '0, 0, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule